// File: doc/BRIEF.md
# Streaming Packet Transform Pipeline

This block sits on a valid/ready packet stream. Every packet carries an identifier, a 4-bit operation code and a 16-bit payload. At the moment a packet is accepted, the payload is rewritten by one of four selectable transforms: pass-through, XOR with a mask, modular add of a constant, or a fixed 4-bit left rotation. The packet then moves through a short elastic pipeline of register slots to the output port. A separate register bank supplies the configuration as plain level inputs. The mode, mask, constant and drop settings are sampled at the same edge that accepts the packet.

A drop filter can discard every packet whose operation code equals a configured value. A discarded packet is removed at the first slot and never reaches the output. Three wrapping counters track accepted, emitted and discarded packets. Each counter steps only on the handshake it describes. A busy flag is high while any slot holds a packet. While busy is low, the counters obey the balance emitted + discarded = accepted. A synchronous soft clear empties the pipeline and zeroes the counters.

Top module: `stream_pkt_modifier`

## Requirements
- R1: With mode = 0, the output payload equals the input payload.
- R2: With mode = 1, the output payload is the input payload XOR `xor_mask`.
- R3: With mode = 2, the output payload is the input payload plus `add_value`, modulo 2^16.
- R4: With mode = 3, the output payload is the input payload rotated left by a fixed 4 bits (bits [11:0] move to [15:4], bits [15:12] move to [3:0]).
- R5: When `drop_en` is 1 and the packet's op code equals `drop_code`, the packet is accepted but never appears at the output, and `cnt_drop` increments by one. With `drop_en` = 0, a packet with that code passes normally.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_id`, `out_op` and `out_data` hold their values. When all slots are full and stalled, `in_ready` is 0.
- R7: `cnt_in` steps by one per input handshake. `cnt_out` steps by one per output handshake, never for cycles in which `out_valid` is held under a stall.
- R8: Whenever `busy` is 0, `cnt_out + cnt_drop == cnt_in` (modulo 2^32). After reset, all counters, `busy` and `out_valid` are 0.
- R9: A one-cycle `soft_clear` empties every slot and zeroes all three counters on the next edge. Afterwards the pipeline accepts new packets normally.
- R10: While `enable` is 0, `in_ready` is 0 and no packet is accepted.
- R11: With `out_ready` held at 1, an accepted, non-dropped packet appears at the output within 10 cycles (3 cycles with the default depth).
- R12: Packets leave in the order they were accepted, with their id and op code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows input acceptance when 1 |
| soft_clear | input | 1 | Synchronous clear of slots and counters |
| mode | input | 2 | Transform select: 0 pass, 1 XOR, 2 add, 3 rotate-left-4 |
| xor_mask | input | 16 | Mask for mode 1 |
| add_value | input | 16 | Constant for mode 2 |
| drop_en | input | 1 | Enables the drop filter |
| drop_code | input | 4 | Op code that is discarded |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Input packet accepted this cycle if valid |
| in_id | input | 8 | Input packet identifier |
| in_op | input | 4 | Input packet op code |
| in_data | input | 16 | Input payload |
| out_valid | output | 1 | Output packet present |
| out_ready | input | 1 | Downstream accepts the output packet |
| out_id | output | 8 | Output packet identifier |
| out_op | output | 4 | Output packet op code |
| out_data | output | 16 | Transformed payload |
| busy | output | 1 | Some slot holds a packet |
| cnt_in | output | 32 | Accepted packet count |
| cnt_out | output | 32 | Emitted packet count |
| cnt_drop | output | 32 | Discarded packet count |

## Verification
The hardest state to reach from the ports is a pipeline that is completely full behind a stalled output. In that state every slot is occupied, input acceptance is cut off, and the head packet must stay frozen while the emitted counter stands still. The stimulus holds `out_ready` low and feeds packets until `in_ready` falls. It then watches the head for several cycles before releasing the stall and checking the drain order and counter deltas. The same stalled fill is reused to show that a soft clear empties the slots mid-flight. A dropped packet placed directly ahead of a kept one shows that the discard leaves no gap and no stray output.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic [1:0] {
    XF_PASS = 2'd0,
    XF_XOR  = 2'd1,
    XF_ADD  = 2'd2,
    XF_ROTL = 2'd3
  } xf_mode_e;

  // fixed rotation distance of the rotate transform
  localparam int ROT_AMT = 4;

endpackage

// File: rtl/spm_ingress.sv
module spm_ingress
  import spm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input  xf_mode_e            mode_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [DATA_W-1:0]   mask_i,
  input  logic [DATA_W-1:0]   addv_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic                drop_en_i,
  input  logic [OP_W-1:0]     drop_code_i,
  output logic [DATA_W-1:0]   data_o,
  output logic                drop_o
);

  localparam int RSH = DATA_W - ROT_AMT;

  logic [DATA_W-1:0] rot_data;

  assign rot_data = (data_i << ROT_AMT) | (data_i >> RSH);

  always_comb begin
    unique case (mode_i)
      XF_PASS: data_o = data_i;
      XF_XOR:  data_o = data_i ^ mask_i;
      XF_ADD:  data_o = data_i + addv_i;
      XF_ROTL: data_o = rot_data;
      default: data_o = data_i;
    endcase
  end

  assign drop_o = drop_en_i && (op_i == drop_code_i);

endmodule

// File: rtl/spm_slot.sv
module spm_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         unload,
  input  logic [W-1:0] d,
  output logic         valid_q,
  output logic [W-1:0] data_q
);

  logic valid_nxt;
  logic data_en;

  always_comb begin
    if (clr)         valid_nxt = 1'b0;
    else if (load)   valid_nxt = 1'b1;
    else if (unload) valid_nxt = 1'b0;
    else             valid_nxt = valid_q;
  end

  assign data_en = load && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= d;
  end

  // R6: a held packet is never overwritten by a new load
  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && valid_q && !unload));

  // R6: an occupied slot that is not emptied keeps its contents
  p_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !unload && !clr) |=> (valid_q && $stable(data_q)));

endmodule

// File: rtl/spm_counter.sv
module spm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         q_en;

  assign q_en = clr || inc;

  always_comb begin
    if (clr) q_nxt = '0;
    else     q_nxt = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R7: exactly one step per qualifying event
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (q == $past(q) + 1'b1));

  // R7: no step without an event
  p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(q));

endmodule

// File: rtl/stream_pkt_modifier.sv
module stream_pkt_modifier
  import spm_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              soft_clear,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] xor_mask,
  input  logic [DATA_W-1:0] add_value,
  input  logic              drop_en,
  input  logic [OP_W-1:0]   drop_code,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [OP_W-1:0]   out_op,
  output logic [DATA_W-1:0] out_data,
  output logic              busy,
  output logic [CNT_W-1:0]  cnt_in,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [CNT_W-1:0]  cnt_drop
);

  // slot layout: {id, op, data, drop}
  localparam int SLOT_W  = ID_W + OP_W + DATA_W + 1;
  localparam int DATA_LO = 1;
  localparam int OP_LO   = DATA_LO + DATA_W;
  localparam int ID_LO   = OP_LO + OP_W;
  localparam int LAST    = STAGES - 1;

  logic [DATA_W-1:0] x_data;
  logic              x_drop;
  logic              in_fire;
  logic              drop_fire;
  logic              out_fire;
  logic              head_drop;

  logic [STAGES-1:0] s_valid;
  logic [STAGES-1:0] s_load;
  logic [STAGES-1:0] s_unload;
  logic [STAGES-1:0] s_room;
  logic [SLOT_W-1:0] s_d [STAGES];
  logic [SLOT_W-1:0] s_q [STAGES];

  spm_ingress #(
    .DATA_W (DATA_W),
    .OP_W   (OP_W)
  ) u_ingress (
    .mode_i      (xf_mode_e'(mode)),
    .data_i      (in_data),
    .mask_i      (xor_mask),
    .addv_i      (add_value),
    .op_i        (in_op),
    .drop_en_i   (drop_en),
    .drop_code_i (drop_code),
    .data_o      (x_data),
    .drop_o      (x_drop)
  );

  assign head_drop = s_q[0][0];

  // backward flow-control walk: each slot may move if the slot ahead has room
  always_comb begin
    logic down;
    down = out_ready;
    for (int i = STAGES - 1; i >= 0; i--) begin
      if (i == 0 && head_drop) s_unload[i] = s_valid[i];
      else                     s_unload[i] = s_valid[i] && down;
      s_room[i] = !s_valid[i] || s_unload[i];
      down      = s_room[i];
    end
  end

  assign in_ready = enable && !soft_clear && s_room[0];
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    s_load[0] = in_fire;
    for (int g = 1; g < STAGES; g++) s_load[g] = s_unload[g-1];
    s_load[1] = s_unload[0] && !head_drop;
  end

  assign drop_fire = s_unload[0] && head_drop;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_slot
      if (g == 0) begin : g_head
        assign s_d[g] = {in_id, in_op, x_data, x_drop};
      end else begin : g_tail
        assign s_d[g] = {s_q[g-1][SLOT_W-1:1], 1'b0};
      end

      spm_slot #(
        .W (SLOT_W)
      ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_clear),
        .load    (s_load[g]),
        .unload  (s_unload[g]),
        .d       (s_d[g]),
        .valid_q (s_valid[g]),
        .data_q  (s_q[g])
      );
    end
  endgenerate

  assign out_valid = s_valid[LAST];
  assign out_id    = s_q[LAST][ID_LO +: ID_W];
  assign out_op    = s_q[LAST][OP_LO +: OP_W];
  assign out_data  = s_q[LAST][DATA_LO +: DATA_W];
  assign out_fire  = out_valid && out_ready;
  assign busy      = |s_valid;

  spm_counter #(.W(CNT_W)) u_cnt_in (
    .clk (clk), .rst_n (rst_n), .clr (soft_clear), .inc (in_fire), .q (cnt_in)
  );

  spm_counter #(.W(CNT_W)) u_cnt_out (
    .clk (clk), .rst_n (rst_n), .clr (soft_clear), .inc (out_fire), .q (cnt_out)
  );

  spm_counter #(.W(CNT_W)) u_cnt_drop (
    .clk (clk), .rst_n (rst_n), .clr (soft_clear), .inc (drop_fire), .q (cnt_drop)
  );

  // R6: stalled output holds every field
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !soft_clear) |=>
      (out_valid && $stable(out_id) && $stable(out_op) && $stable(out_data)));

  // R5: a packet flagged for discard never reaches the output slot
  p_no_drop_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !s_q[LAST][0]);

  // R8: counter balance whenever the pipeline is empty
  p_balance_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cnt_out + cnt_drop == cnt_in));

  // R9: soft clear empties slots and zeroes counters
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clear |=> (!busy && cnt_in == '0 && cnt_out == '0 && cnt_drop == '0));

  // R10: no acceptance while disabled
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !in_ready);

endmodule

// File: tb/stream_pkt_modifier_tb.sv
module stream_pkt_modifier_tb;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        soft_clear;
  logic [1:0]  mode;
  logic [15:0] xor_mask;
  logic [15:0] add_value;
  logic        drop_en;
  logic [3:0]  drop_code;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_id;
  logic [3:0]  in_op;
  logic [15:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_id;
  logic [3:0]  out_op;
  logic [15:0] out_data;
  logic        busy;
  logic [31:0] cnt_in;
  logic [31:0] cnt_out;
  logic [31:0] cnt_drop;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;

  stream_pkt_modifier u_dut (
    .clk (clk), .rst_n (rst_n), .enable (enable), .soft_clear (soft_clear),
    .mode (mode), .xor_mask (xor_mask), .add_value (add_value),
    .drop_en (drop_en), .drop_code (drop_code),
    .in_valid (in_valid), .in_ready (in_ready), .in_id (in_id),
    .in_op (in_op), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_id (out_id),
    .out_op (out_op), .out_data (out_data),
    .busy (busy), .cnt_in (cnt_in), .cnt_out (cnt_out), .cnt_drop (cnt_drop)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {mode[37:36], op[35:32], data[31:16], expected[15:0]}; mask A5F0, add 8001
  localparam int NV = 10;
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 4'h1, 16'h1234, 16'h1234},
    {2'd1, 4'h2, 16'h1234, 16'hB7C4},
    {2'd2, 4'h3, 16'h1234, 16'h9235},
    {2'd3, 4'h4, 16'h1234, 16'h2341},
    {2'd2, 4'h7, 16'hFFFF, 16'h8000},
    {2'd3, 4'h8, 16'hF00F, 16'h00FF},
    {2'd1, 4'h9, 16'hFFFF, 16'h5A0F},
    {2'd0, 4'hA, 16'h0000, 16'h0000},
    {2'd3, 4'hB, 16'h8001, 16'h0018},
    {2'd2, 4'hC, 16'h7FFF, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic send(input logic [7:0] id, input logic [3:0] op, input logic [15:0] data);
    in_id    = id;
    in_op    = op;
    in_data  = data;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // called at a negedge with out_ready high; returns at the negedge after consumption
  task automatic recv(output logic [7:0] id, output logic [3:0] op,
                      output logic [15:0] data, output int cyc);
    cyc = 0;
    forever begin
      cyc++;
      if (out_valid || cyc > 40) break;
      @(negedge clk);
    end
    id   = out_id;
    op   = out_op;
    data = out_data;
    @(negedge clk);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 20000 && !finished; wd++) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog R11 actual=%0d expected=finish", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rid;
    logic [3:0]  rop;
    logic [15:0] rdata;
    int          lat;
    logic [31:0] base_in;
    logic [31:0] base_out;
    string       mtag [4];
    mtag[0] = "R1"; mtag[1] = "R2"; mtag[2] = "R3"; mtag[3] = "R4";

    rst_n = 1'b0; enable = 1'b1; soft_clear = 1'b0; mode = 2'd0;
    xor_mask = 16'hA5F0; add_value = 16'h8001; drop_en = 1'b0; drop_code = 4'h5;
    in_valid = 1'b0; in_id = '0; in_op = '0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R8)
    chk("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R8 reset busy", {31'd0, busy}, 32'd0);
    chk("R8 reset cnt_in", cnt_in, 32'd0);
    chk("R8 reset cnt_out", cnt_out, 32'd0);
    chk("R8 reset cnt_drop", cnt_drop, 32'd0);
    chk("R10 reset in_ready enabled", {31'd0, in_ready}, 32'd1);

    // vector table: transforms, ordering, latency
    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][37:36];
      send(8'(i), VEC[i][35:32], VEC[i][31:16]);
      recv(rid, rop, rdata, lat);
      chk(mtag[VEC[i][37:36]], {16'd0, rdata}, {16'd0, VEC[i][15:0]});
      chk("R12 id", {24'd0, rid}, 32'(i));
      chk("R12 op", {28'd0, rop}, {28'd0, VEC[i][35:32]});
      chk("R11 latency", 32'(lat <= 10), 32'd1);
    end
    chk("R7 cnt_in after table", cnt_in, 32'(NV));
    chk("R7 cnt_out after table", cnt_out, 32'(NV));

    // drop filter (R5)
    mode = 2'd0; drop_en = 1'b1; drop_code = 4'h5;
    send(8'h20, 4'h5, 16'hDEAD);
    send(8'h21, 4'h6, 16'hBEEF);
    recv(rid, rop, rdata, lat);
    chk("R5 kept packet follows dropped one", {24'd0, rid}, 32'h21);
    chk("R5 kept payload", {16'd0, rdata}, 32'hBEEF);
    repeat (4) @(negedge clk);
    chk("R5 no stray output", {31'd0, out_valid}, 32'd0);
    chk("R5 cnt_drop", cnt_drop, 32'd1);
    chk("R8 idle balance", cnt_out + cnt_drop, cnt_in);
    chk("R8 busy idle", {31'd0, busy}, 32'd0);
    drop_en = 1'b0;
    send(8'h22, 4'h5, 16'h0F0F);
    recv(rid, rop, rdata, lat);
    chk("R5 drop disabled passes", {24'd0, rid}, 32'h22);
    chk("R5 cnt_drop unchanged", cnt_drop, 32'd1);

    // full stall (R6, R7, R12)
    base_in  = cnt_in;
    base_out = cnt_out;
    out_ready = 1'b0;
    send(8'h30, 4'h0, 16'h1111);
    send(8'h31, 4'h1, 16'h2222);
    send(8'h32, 4'h2, 16'h3333);
    #1;
    chk("R6 full blocks input", {31'd0, in_ready}, 32'd0);
    chk("R6 head id", {24'd0, out_id}, 32'h30);
    repeat (5) @(negedge clk);
    chk("R6 head held valid", {31'd0, out_valid}, 32'd1);
    chk("R6 head held id", {24'd0, out_id}, 32'h30);
    chk("R6 head held data", {16'd0, out_data}, 32'h1111);
    chk("R7 cnt_out frozen under stall", cnt_out, base_out);
    chk("R7 cnt_in stepped per accept", cnt_in, base_in + 32'd3);
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      recv(rid, rop, rdata, lat);
      chk("R12 drain order", {24'd0, rid}, 32'h30 + 32'(k));
    end
    chk("R7 cnt_out stepped per handshake", cnt_out, base_out + 32'd3);
    chk("R8 balance after drain", cnt_out + cnt_drop, cnt_in);

    // enable gate (R10)
    enable = 1'b0;
    base_in = cnt_in;
    in_valid = 1'b1; in_id = 8'h40;
    repeat (4) begin
      @(negedge clk);
      chk("R10 in_ready low while disabled", {31'd0, in_ready}, 32'd0);
    end
    in_valid = 1'b0;
    chk("R10 cnt_in unchanged", cnt_in, base_in);
    chk("R10 no output", {31'd0, out_valid}, 32'd0);
    enable = 1'b1;

    // soft clear mid-flight (R9)
    out_ready = 1'b0;
    send(8'h50, 4'h3, 16'hAAAA);
    send(8'h51, 4'h3, 16'hBBBB);
    chk("R9 busy before clear", {31'd0, busy}, 32'd1);
    soft_clear = 1'b1;
    @(negedge clk);
    soft_clear = 1'b0;
    chk("R9 busy cleared", {31'd0, busy}, 32'd0);
    chk("R9 out_valid cleared", {31'd0, out_valid}, 32'd0);
    chk("R9 cnt_in cleared", cnt_in, 32'd0);
    chk("R9 cnt_out cleared", cnt_out, 32'd0);
    chk("R9 cnt_drop cleared", cnt_drop, 32'd0);
    out_ready = 1'b1;
    mode = 2'd3;
    send(8'h52, 4'h4, 16'hABCD);
    recv(rid, rop, rdata, lat);
    chk("R9 usable after clear id", {24'd0, rid}, 32'h52);
    chk("R4 rotate after clear", {16'd0, rdata}, 32'hBCDA);
    chk("R9 cnt_in restarted", cnt_in, 32'd1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule